// File: doc/BRIEF.md
# I2C-to-Wishbone Register Bridge

This block sits above a byte-level I2C target and turns a small register protocol into single Wishbone classic accesses. It watches the target's per-byte handshake: a one-cycle completion pulse, a status code, the received byte and the current transfer direction. It supplies the byte to transmit and drives a Wishbone master port with 32-bit data.

Once the target reports an address match, the host sends two bytes that make up a 16-bit register address. The bridge first issues a probe read to check that the register exists. A slave error, or no reply at all, sends it back to idle. If the probe is acknowledged, the host has two options. It can send four data bytes, which the bridge commits as one Wishbone write. Or it can issue a repeated start in the read direction. The bridge then performs a real Wishbone read and hands the four bytes of the word to the target one at a time.

Top module: `i2c_wb_bridge`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are low and `tgt_tx_o` is zero.
- R2: Status codes on `tgt_stat_i` are 1 = address matched, 2 = byte received and acknowledged, 3 = byte sent and acknowledged by the host, 4 = byte sent and not acknowledged, 5 = stop condition. After a code-1 event, the next two code-2 bytes form the 16-bit Wishbone address, most significant byte first.
- R3: Before any data access, the bridge performs a probe read (`wb_we_o` low) to the collected address. If the slave answers with err, the bridge returns to idle, and any data bytes that follow produce no write.
- R4: If the probe is acknowledged and `tgt_rd_i` still equals its value at the address match, the next four code-2 bytes are assembled most significant byte first. They are written as one Wishbone write (`wb_we_o` high) to the stored address.
- R5: If the probe is acknowledged and a code-1 event then arrives with `tgt_rd_i` different from its latched value, the bridge performs a Wishbone read. `tgt_tx_o` then shows the most significant byte of the word, and the next byte follows after each code-3 event.
- R6: `wb_cyc_o` and `wb_stb_o` rise and fall together. While a cycle is open without ack or err, they stay high and `wb_adr_o`, `wb_we_o` and `wb_dat_o` stay stable.
- R7: If the slave gives neither ack nor err, the cycle is abandoned after exactly `TMO_CYC` cycles and the bridge returns to idle.
- R8: A stop (code 5) while write bytes are being collected, or a code 4 during the read path, returns the bridge to idle with no Wishbone write. A fresh transaction then works normally.
- R9: In idle, completion events with any code other than 1 are ignored and start no Wishbone access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_done_i | input | 1 | One-cycle completion pulse from the I2C target |
| tgt_stat_i | input | 3 | Status code of the completed event |
| tgt_rx_i | input | 8 | Byte received by the target |
| tgt_rd_i | input | 1 | Current transfer direction, 1 = host reads |
| tgt_tx_o | output | 8 | Byte the target sends next |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | ADR_W | Wishbone address |
| wb_dat_o | output | DAT_W | Wishbone write data |
| wb_dat_i | input | DAT_W | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |

## Verification
A table of address and word pairs is written through the bridge and then read back. The words cover all ones, a single low byte and a single edge bit, so that any byte-order or shift fault shows up as a wrong byte in a known position. An address whose only set bit is in the high byte tells a correct address order apart from a swapped one, because the swapped value would hit an existing register. A silent address, an aborted write, a NACK part-way through a read and stray bytes in idle then confirm that none of these leaves a write behind, and that the next transaction starts cleanly.

// File: rtl/i2c_wb_pkg.sv
package i2c_wb_pkg;

   typedef enum logic [2:0] {
      TGT_NONE    = 3'd0,
      TGT_ADDR_HIT = 3'd1,
      TGT_RX_ACK  = 3'd2,
      TGT_TX_ACK  = 3'd3,
      TGT_TX_NACK = 3'd4,
      TGT_STOP    = 3'd5
   } tgt_stat_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ADDR,
      SQ_PROBE,
      SQ_OPCHK,
      SQ_WCOL,
      SQ_WWRITE,
      SQ_WREAD,
      SQ_RSEND
   } seq_state_e;

endpackage

// File: rtl/i2c_wb_bytereg.sv
module i2c_wb_bytereg #(
   parameter int W         = 32,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sh_en,
   input  logic [7:0]   sh_in,
   input  logic         ld_en,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);

   logic [W-1:0] shifted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shifted = {q[W-9:0], sh_in};
      end else begin : g_lsb
         assign shifted = {sh_in, q[W-1:8]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld_en) begin
         q <= ld_val;
      end else if (sh_en) begin
         q <= shifted;
      end
   end

endmodule

// File: rtl/i2c_wb_master.sv
module i2c_wb_master #(
   parameter int DAT_W   = 32,
   parameter int TMO_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             we_req,
   input  logic             ack,
   input  logic             err,
   input  logic [DAT_W-1:0] rdat_in,
   output logic             busy,
   output logic             we,
   output logic             ok,
   output logic             bad,
   output logic [DAT_W-1:0] rdat
);

   localparam int TCNT_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

   logic expire;

   generate
      if (TMO_CYC > 0) begin : g_tmo
         logic [TCNT_W-1:0] tcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || go || !busy) begin
               tcnt <= '0;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
         assign expire = busy && (tcnt == TCNT_W'(TMO_CYC - 1));
      end else begin : g_no_tmo
         assign expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         we   <= 1'b0;
         ok   <= 1'b0;
         bad  <= 1'b0;
         rdat <= '0;
      end else begin
         ok  <= 1'b0;
         bad <= 1'b0;
         if (go && !busy) begin
            busy <= 1'b1;
            we   <= we_req;
         end else if (busy) begin
            if (ack) begin
               busy <= 1'b0;
               we   <= 1'b0;
               ok   <= 1'b1;
               rdat <= rdat_in;
            end else if (err || expire) begin
               busy <= 1'b0;
               we   <= 1'b0;
               bad  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/i2c_wb_seq.sv
module i2c_wb_seq
   import i2c_wb_pkg::*;
#(
   parameter int ADR_BYTES = 2,
   parameter int DAT_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic [2:0] stat,
   input  logic       rd_dir,
   input  logic       wb_ok,
   input  logic       wb_bad,
   output logic       adr_sh,
   output logic       dat_sh,
   output logic       dat_ld,
   output logic       wb_go,
   output logic       wb_we_req
);

   localparam int MAXB  = (ADR_BYTES > DAT_BYTES) ? ADR_BYTES : DAT_BYTES;
   localparam int CNT_W = $clog2(MAXB + 1);
   localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_BYTES - 1);
   localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DAT_BYTES - 1);

   seq_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             dir_q;

   logic ev_hit, ev_rx, ev_txa;
   assign ev_hit = done && (stat == TGT_ADDR_HIT);
   assign ev_rx  = done && (stat == TGT_RX_ACK);
   assign ev_txa = done && (stat == TGT_TX_ACK);

   assign adr_sh    = (st == SQ_ADDR) && ev_rx;
   assign dat_sh    = ((st == SQ_OPCHK) && ev_rx && (rd_dir == dir_q)) ||
                      ((st == SQ_WCOL) && ev_rx) ||
                      ((st == SQ_RSEND) && ev_txa);
   assign dat_ld    = (st == SQ_WREAD) && wb_ok;
   assign wb_we_req = (st == SQ_WWRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         cnt   <= '0;
         dir_q <= 1'b0;
         wb_go <= 1'b0;
      end else begin
         wb_go <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (ev_hit) begin
                  dir_q <= rd_dir;
                  cnt   <= '0;
                  st    <= SQ_ADDR;
               end
            end
            SQ_ADDR: begin
               if (ev_rx) begin
                  if (cnt == ADR_LAST) begin
                     st    <= SQ_PROBE;
                     wb_go <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else if (done) begin
                  st <= SQ_IDLE;
               end
            end
            SQ_PROBE: begin
               if (wb_ok) begin
                  st <= SQ_OPCHK;
               end else if (wb_bad) begin
                  st <= SQ_IDLE;
               end
            end
            SQ_OPCHK: begin
               if (ev_hit && (rd_dir != dir_q)) begin
                  st    <= SQ_WREAD;
                  wb_go <= 1'b1;
               end else if (ev_rx && (rd_dir == dir_q)) begin
                  cnt <= CNT_W'(1);
                  st  <= SQ_WCOL;
               end else if (done) begin
                  st <= SQ_IDLE;
               end
            end
            SQ_WCOL: begin
               if (ev_rx) begin
                  if (cnt == DAT_LAST) begin
                     st    <= SQ_WWRITE;
                     wb_go <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else if (done) begin
                  st <= SQ_IDLE;
               end
            end
            SQ_WWRITE: begin
               if (wb_ok || wb_bad) begin
                  st <= SQ_IDLE;
               end
            end
            SQ_WREAD: begin
               if (wb_ok) begin
                  cnt <= '0;
                  st  <= SQ_RSEND;
               end else if (wb_bad) begin
                  st <= SQ_IDLE;
               end
            end
            SQ_RSEND: begin
               if (ev_txa) begin
                  if (cnt == DAT_LAST) begin
                     st <= SQ_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else if (done) begin
                  st <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_wb_bridge.sv
module i2c_wb_bridge #(
   parameter int ADR_W     = 16,
   parameter int DAT_W     = 32,
   parameter int TMO_CYC   = 64,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tgt_done_i,
   input  logic [2:0]       tgt_stat_i,
   input  logic [7:0]       tgt_rx_i,
   input  logic             tgt_rd_i,
   output logic [7:0]       tgt_tx_o,
   output logic             wb_cyc_o,
   output logic             wb_stb_o,
   output logic             wb_we_o,
   output logic [ADR_W-1:0] wb_adr_o,
   output logic [DAT_W-1:0] wb_dat_o,
   input  logic [DAT_W-1:0] wb_dat_i,
   input  logic             wb_ack_i,
   input  logic             wb_err_i
);

   localparam int ADR_BYTES = ADR_W / 8;
   localparam int DAT_BYTES = DAT_W / 8;

   generate
      if ((ADR_W % 8) != 0 || ADR_W < 16) begin : g_chk_adr
         $error("ADR_W must be a multiple of 8 and at least 16");
      end
      if ((DAT_W % 8) != 0 || DAT_W < 16) begin : g_chk_dat
         $error("DAT_W must be a multiple of 8 and at least 16");
      end
      if (TMO_CYC < 0) begin : g_chk_tmo
         $error("TMO_CYC must not be negative");
      end
   endgenerate

   logic             adr_sh, dat_sh, dat_ld, wb_go, wb_we_req;
   logic             wb_ok, wb_bad, wb_busy;
   logic [DAT_W-1:0] rdat;
   logic [DAT_W-1:0] dat_q;

   i2c_wb_seq #(
      .ADR_BYTES(ADR_BYTES),
      .DAT_BYTES(DAT_BYTES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (tgt_done_i),
      .stat     (tgt_stat_i),
      .rd_dir   (tgt_rd_i),
      .wb_ok    (wb_ok),
      .wb_bad   (wb_bad),
      .adr_sh   (adr_sh),
      .dat_sh   (dat_sh),
      .dat_ld   (dat_ld),
      .wb_go    (wb_go),
      .wb_we_req(wb_we_req)
   );

   i2c_wb_bytereg #(
      .W        (ADR_W),
      .MSB_FIRST(1'b1)
   ) u_adr (
      .clk   (clk),
      .rst_n (rst_n),
      .sh_en (adr_sh),
      .sh_in (tgt_rx_i),
      .ld_en (1'b0),
      .ld_val({ADR_W{1'b0}}),
      .q     (wb_adr_o)
   );

   i2c_wb_bytereg #(
      .W        (DAT_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_dat (
      .clk   (clk),
      .rst_n (rst_n),
      .sh_en (dat_sh),
      .sh_in (tgt_rx_i),
      .ld_en (dat_ld),
      .ld_val(rdat),
      .q     (dat_q)
   );

   i2c_wb_master #(
      .DAT_W  (DAT_W),
      .TMO_CYC(TMO_CYC)
   ) u_wbm (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (wb_go),
      .we_req (wb_we_req),
      .ack    (wb_ack_i),
      .err    (wb_err_i),
      .rdat_in(wb_dat_i),
      .busy   (wb_busy),
      .we     (wb_we_o),
      .ok     (wb_ok),
      .bad    (wb_bad),
      .rdat   (rdat)
   );

   generate
      if (MSB_FIRST) begin : g_tx_msb
         assign tgt_tx_o = dat_q[DAT_W-1 -: 8];
      end else begin : g_tx_lsb
         assign tgt_tx_o = dat_q[7:0];
      end
   endgenerate

   assign wb_cyc_o = wb_busy;
   assign wb_stb_o = wb_busy;
   assign wb_dat_o = dat_q;

endmodule

// File: rtl/i2c_wb_bridge_chk.sv
module i2c_wb_bridge_chk #(
   parameter int ADR_W   = 16,
   parameter int DAT_W   = 32,
   parameter int TMO_CYC = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wb_cyc_o,
   input logic             wb_stb_o,
   input logic             wb_we_o,
   input logic [ADR_W-1:0] wb_adr_o,
   input logic [DAT_W-1:0] wb_dat_o,
   input logic             wb_ack_i,
   input logic             wb_err_i
);

   logic [31:0]      run;
   logic             probe_ok;
   logic [ADR_W-1:0] probe_adr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run       <= '0;
         probe_ok  <= 1'b0;
         probe_adr <= '0;
      end else begin
         if (wb_cyc_o) begin
            if (run != 32'hFFFF_FFFF) run <= run + 1;
         end else begin
            run <= '0;
         end
         if (wb_cyc_o && !wb_we_o && wb_ack_i) begin
            probe_ok  <= 1'b1;
            probe_adr <= wb_adr_o;
         end
      end
   end

   // R6: strobe follows cycle
   a_r6_cyc_stb: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o == wb_stb_o);

   // R6: open cycle is held until a response or the time limit
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && !wb_ack_i && !wb_err_i &&
       (TMO_CYC == 0 || run != 32'(TMO_CYC - 1))) |=> wb_cyc_o);

   // R6: address, direction and data stay put while waiting
   a_r6_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && !wb_ack_i && !wb_err_i) |=>
      (!wb_cyc_o || ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o))));

   // R7: no cycle outlives the time limit
   a_r7_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o |-> (TMO_CYC == 0 || run < 32'(TMO_CYC)));

   // R3: a write only goes to an address whose read was acknowledged
   a_r3_probe_first: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && wb_we_o) |-> (probe_ok && probe_adr == wb_adr_o));

endmodule

bind i2c_wb_bridge i2c_wb_bridge_chk #(
   .ADR_W  (ADR_W),
   .DAT_W  (DAT_W),
   .TMO_CYC(TMO_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wb_cyc_o(wb_cyc_o),
   .wb_stb_o(wb_stb_o),
   .wb_we_o (wb_we_o),
   .wb_adr_o(wb_adr_o),
   .wb_dat_o(wb_dat_o),
   .wb_ack_i(wb_ack_i),
   .wb_err_i(wb_err_i)
);

// File: tb/i2c_wb_bridge_tb.sv
module i2c_wb_bridge_tb;

   localparam int TMO = 64;
   localparam int NV  = 5;
   localparam logic [47:0] VEC [NV] = '{
      {16'h0000, 32'h1234_5678},
      {16'h0003, 32'hDEAD_BEEF},
      {16'h0007, 32'h0000_00FF},
      {16'h000C, 32'h8000_0001},
      {16'h000F, 32'hFFFF_FFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done = 1'b0;
   logic [2:0]  stat = 3'd0;
   logic [7:0]  rx = 8'd0;
   logic        rd = 1'b0;
   logic [7:0]  tx;
   logic        cyc, stb, we, ack, err;
   logic [15:0] adr;
   logic [31:0] dat_o, dat_i;

   always #2.5 clk = ~clk;

   i2c_wb_bridge #(.TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .tgt_done_i(done), .tgt_stat_i(stat), .tgt_rx_i(rx), .tgt_rd_i(rd),
      .tgt_tx_o(tx),
      .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr),
      .wb_dat_o(dat_o), .wb_dat_i(dat_i), .wb_ack_i(ack), .wb_err_i(err)
   );

   // Wishbone slave: 16 registers, one silent address
   logic [31:0] mem [16];
   logic        valid, silent;
   assign valid  = adr < 16'd16;
   assign silent = adr == 16'hBEEF;
   assign ack    = cyc && stb && valid;
   assign err    = cyc && stb && !valid && !silent;
   assign dat_i  = mem[adr[3:0]];

   int          wr_cnt, rd_cnt, n_starts, run, max_run, skew;
   logic [15:0] last_wr_adr, last_rd_adr;
   logic [31:0] last_wr_dat;
   logic        cyc_d;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE_0000 | i;
         wr_cnt <= 0; rd_cnt <= 0; n_starts <= 0; run <= 0; max_run <= 0;
         skew <= 0; cyc_d <= 1'b0;
         last_wr_adr <= '0; last_rd_adr <= '0; last_wr_dat <= '0;
      end else begin
         cyc_d <= cyc;
         if (cyc != stb) skew <= skew + 1;
         if (cyc && !cyc_d) n_starts <= n_starts + 1;
         if (cyc) run <= run + 1;
         else begin
            if (run > max_run) max_run <= run;
            run <= 0;
         end
         if (cyc && !we) last_rd_adr <= adr;
         if (ack && we) begin
            mem[adr[3:0]] <= dat_o;
            wr_cnt <= wr_cnt + 1;
            last_wr_adr <= adr;
            last_wr_dat <= dat_o;
         end
         if (ack && !we) rd_cnt <= rd_cnt + 1;
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit cond, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ev(input logic [2:0] s, input logic [7:0] b, input logic d);
      @(negedge clk);
      done = 1'b1; stat = s; rx = b; rd = d;
      @(negedge clk);
      done = 1'b0; stat = 3'd0;
      repeat (TMO + 16) @(negedge clk);
   endtask

   task automatic send_adr(input logic [15:0] a);
      ev(3'd1, 8'h00, 1'b0);
      ev(3'd2, a[15:8], 1'b0);
      ev(3'd2, a[7:0], 1'b0);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] w);
      send_adr(a);
      for (int k = 3; k >= 0; k--) ev(3'd2, w[k*8 +: 8], 1'b0);
      ev(3'd5, 8'h00, 1'b0);
   endtask

   task automatic do_read(input logic [15:0] a, output logic [31:0] w);
      send_adr(a);
      ev(3'd1, 8'h00, 1'b1);
      for (int k = 3; k >= 0; k--) begin
         w[k*8 +: 8] = tx;
         ev(3'd3, 8'h00, 1'b1);
      end
      ev(3'd5, 8'h00, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] got;
      int          w0, r0, s0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1
      chk(!cyc && !stb && !we, "R1 bus idle after reset", {29'd0, cyc, stb, we}, 32'd0);
      chk(tx == 8'h00, "R1 tx byte after reset", {24'd0, tx}, 32'd0);

      // vector table: write then read back
      for (int v = 0; v < NV; v++) begin
         w0 = wr_cnt; r0 = rd_cnt;
         do_write(VEC[v][47:32], VEC[v][31:0]);
         chk(rd_cnt == r0 + 1, "R3 one probe read before write", rd_cnt, r0 + 1);
         chk(wr_cnt == w0 + 1, "R4 one write committed", wr_cnt, w0 + 1);
         chk(last_wr_adr == VEC[v][47:32], "R2 write address", {16'd0, last_wr_adr},
             {16'd0, VEC[v][47:32]});
         chk(last_wr_dat == VEC[v][31:0], "R4 write data MSB first", last_wr_dat,
             VEC[v][31:0]);
         do_read(VEC[v][47:32], got);
         chk(got == VEC[v][31:0], "R5 read bytes MSB first", got, VEC[v][31:0]);
         chk(wr_cnt == w0 + 1, "R5 read issues no write", wr_cnt, w0 + 1);
      end

      // R2/R3: high-byte-only address gets err; bytes after it write nothing
      w0 = wr_cnt;
      do_write(16'h0100, 32'hAAAA_5555);
      chk(last_rd_adr == 16'h0100, "R2 address byte order", {16'd0, last_rd_adr},
          32'h0000_0100);
      chk(wr_cnt == w0, "R3 err probe blocks write", wr_cnt, w0);
      chk(mem[1] == 32'hC0DE_0001, "R3 register 1 untouched", mem[1], 32'hC0DE_0001);

      // R7: silent address
      max_run = 0;
      w0 = wr_cnt;
      do_write(16'hBEEF, 32'h0101_0101);
      chk(max_run == TMO, "R7 cycle length at time limit", max_run, TMO);
      chk(!cyc && wr_cnt == w0, "R7 back to idle, no write", wr_cnt, w0);

      // R8: stop during write collection
      w0 = wr_cnt;
      send_adr(16'h0003);
      ev(3'd2, 8'h11, 1'b0);
      ev(3'd2, 8'h22, 1'b0);
      ev(3'd5, 8'h00, 1'b0);
      chk(wr_cnt == w0, "R8 stop aborts write", wr_cnt, w0);
      // R9: stray bytes in idle start nothing
      s0 = n_starts;
      ev(3'd2, 8'h33, 1'b0);
      ev(3'd2, 8'h44, 1'b0);
      ev(3'd3, 8'h00, 1'b0);
      chk(n_starts == s0, "R9 idle ignores non-match events", n_starts, s0);
      do_read(16'h0003, got);
      chk(got == 32'hDEAD_BEEF, "R8 register 3 kept after stop", got, 32'hDEAD_BEEF);

      // R8: NACK part-way through a read
      send_adr(16'h0007);
      ev(3'd1, 8'h00, 1'b1);
      ev(3'd3, 8'h00, 1'b1);
      ev(3'd4, 8'h00, 1'b1);
      ev(3'd5, 8'h00, 1'b0);
      do_read(16'h000C, got);
      chk(got == 32'h8000_0001, "R8 fresh read after NACK", got, 32'h8000_0001);

      // R6
      chk(skew == 0, "R6 cyc and stb together", skew, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule